// File: doc/BRIEF.md
# Packet Timestamp Capture Unit

This block records when qualifying packets cross each port in each direction. A free-running 64-bit time value is presented on `time_in`. Each port has a receive bank and a transmit bank. A bank commits a capture in the cycle its packet event is valid and three conditions hold: the packet type matched, the frame check sequence was good, and the frame held a whole number of octets. On a commit, the bank stores the time as two 32-bit words, plus the packet's 16-bit sequence ID and 48-bit source UUID. Two extra banks are triggered by GPIO events and store only the time. The stored value is the raw time of the commit cycle. The fixed pipeline latency of the event path is left for software to remove (about 30 ns at 100 Mbps and 120 ns at 10 Mbps).

Every bank owns one bit in a shared status vector, with a matching enable bit. The interrupt line is the OR of the flags that are enabled. Software clears flags by writing ones. Each bank has its own lock enable. While the lock is on and the bank's flag is pending, the bank's registers hold the first capture, and capture resumes once the flag is cleared.

Packet events are single-cycle strobes qualified by their valid bit. The block accepts an event in every cycle and never applies back-pressure, so the event inputs have no ready signal. Control and status pins are plain levels.

Top module: `ts_capture_unit`

## Requirements
- R1: A packet bank commits only in a cycle where its valid, type-match, FCS-good and whole-octet inputs are all 1. If any of them is 0, the bank's registers and flag are left unchanged.
- R2: On a commit, the bank's high word takes `time_in[63:32]` and its low word takes `time_in[31:0]`, both sampled in the commit cycle. No latency correction is applied. The new values appear on the outputs after that clock edge.
- R3: On a packet commit, the upper ID word takes the sequence ID in bits 31:16 and UUID bits 47:32 in bits 15:0. The lower ID word takes UUID bits 31:0.
- R4: A commit sets the bank's flag. Bank numbering is as follows: bank 2*p is receive of port p, bank 2*p+1 is transmit of port p, and bank 2*NPORTS+g is GPIO g. The same index is used in `flags`, `int_en`, `lock_en`, `flag_clr`, and in the 32-bit slices of the capture outputs.
- R5: `irq` is 1 exactly when some bank has both its flag and its `int_en` bit set.
- R6: A cycle with `flag_clr_we`=1 clears every flag whose `flag_clr` bit is 1. Bits written as 0, and any cycle with `flag_clr_we`=0, leave the flags unchanged.
- R7: While a bank's `lock_en` bit is 1 and its flag is set, new commits do not change that bank's registers. After the flag is cleared, the next commit is stored.
- R8: With the lock off, every commit overwrites the bank's registers, and the flag stays set until it is cleared.
- R9: If a commit and a clear of the same flag occur in one cycle, the flag stays set and the registers take the new values, even when the bank is locked.
- R10: A `gpio_evt` pulse commits the matching GPIO bank's time words. It follows the same flag, lock and clear rules as a packet bank.
- R11: After reset, all capture registers, all flags and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| time_in | input | 64 | Free-running time value |
| pkt_valid | input | NPKT | Packet event strobe per packet bank |
| pkt_type_ok | input | NPKT | Packet type matched |
| pkt_fcs_ok | input | NPKT | Frame check sequence good |
| pkt_whole_octets | input | NPKT | Frame length is a whole number of octets |
| pkt_seq_id | input | NPKT*16 | Sequence ID per packet bank |
| pkt_src_uuid | input | NPKT*48 | Source UUID per packet bank |
| gpio_evt | input | NGPIO | GPIO capture strobes |
| lock_en | input | NB | Per-bank lock enable |
| int_en | input | NB | Per-bank interrupt enable |
| flag_clr_we | input | 1 | Write strobe for the flag clear |
| flag_clr | input | NB | Write-one-to-clear mask |
| flags | output | NB | Capture flags |
| irq | output | 1 | Interrupt request |
| cap_hi | output | NB*32 | Captured time, high words |
| cap_lo | output | NB*32 | Captured time, low words |
| id_hi | output | NPKT*32 | Sequence ID and UUID high bits |
| id_lo | output | NPKT*32 | UUID low bits |

## Verification
A wrong flag bit appears on `flags`, and through `irq`, one clock after the event or clear that produced it. A wrong flag also changes the lock decision for that bank. A bad lock decision shows on the capture outputs as a value that changed, or failed to change, right after the next qualifying commit on that bank. A wrong qualification term shows at the next strobe where only that term is low. Every cycle, the bench compares all banks against its model, so any such divergence is reported within one clock of the stimulus that reveals it.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;
  localparam int TS_W   = 64;
  localparam int WORD_W = 32;
  localparam int SEQ_W  = 16;
  localparam int UUID_W = 48;
endpackage

// File: rtl/ts_cap_qual.sv
module ts_cap_qual (
  input  logic valid_i,
  input  logic type_ok_i,
  input  logic fcs_ok_i,
  input  logic whole_i,
  output logic commit_o
);
  always_comb begin
    commit_o = valid_i & type_ok_i & fcs_ok_i & whole_i;
  end
endmodule

// File: rtl/ts_cap_lockctl.sv
module ts_cap_lockctl (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  input  logic clr_i,
  input  logic lock_i,
  output logic we_o,
  output logic flag_o
);
  logic flag_q;
  logic held;

  always_comb begin
    held = lock_i & flag_q & ~clr_i;
    we_o = fire_i & ~held;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (fire_i) flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> flag_o);
  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !fire_i) |=> !flag_o);
endmodule

// File: rtl/ts_cap_clkreg.sv
module ts_cap_clkreg
  import ts_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [TS_W-1:0]   time_i,
  output logic [WORD_W-1:0] hi_o,
  output logic [WORD_W-1:0] lo_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_o <= '0;
      lo_o <= '0;
    end else if (we_i) begin
      hi_o <= time_i[TS_W-1:WORD_W];
      lo_o <= time_i[WORD_W-1:0];
    end
  end
endmodule

// File: rtl/ts_cap_idreg.sv
module ts_cap_idreg
  import ts_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [SEQ_W-1:0]  seq_i,
  input  logic [UUID_W-1:0] uuid_i,
  output logic [WORD_W-1:0] hi_o,
  output logic [WORD_W-1:0] lo_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_o <= '0;
      lo_o <= '0;
    end else if (we_i) begin
      hi_o <= {seq_i, uuid_i[UUID_W-1:WORD_W]};
      lo_o <= uuid_i[WORD_W-1:0];
    end
  end
endmodule

// File: rtl/ts_capture_unit.sv
module ts_capture_unit
  import ts_cap_pkg::*;
#(
  parameter  int NPORTS = 2,
  parameter  int NGPIO  = 2,
  localparam int NPKT   = 2 * NPORTS,
  localparam int NB     = NPKT + NGPIO
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [TS_W-1:0]        time_in,
  input  logic [NPKT-1:0]        pkt_valid,
  input  logic [NPKT-1:0]        pkt_type_ok,
  input  logic [NPKT-1:0]        pkt_fcs_ok,
  input  logic [NPKT-1:0]        pkt_whole_octets,
  input  logic [NPKT*SEQ_W-1:0]  pkt_seq_id,
  input  logic [NPKT*UUID_W-1:0] pkt_src_uuid,
  input  logic [NGPIO-1:0]       gpio_evt,
  input  logic [NB-1:0]          lock_en,
  input  logic [NB-1:0]          int_en,
  input  logic                   flag_clr_we,
  input  logic [NB-1:0]          flag_clr,
  output logic [NB-1:0]          flags,
  output logic                   irq,
  output logic [NB*WORD_W-1:0]   cap_hi,
  output logic [NB*WORD_W-1:0]   cap_lo,
  output logic [NPKT*WORD_W-1:0] id_hi,
  output logic [NPKT*WORD_W-1:0] id_lo
);
  logic [NB-1:0] commit;
  logic [NB-1:0] clr_eff;
  logic [NB-1:0] wr;

  assign clr_eff = flag_clr & {NB{flag_clr_we}};

  for (genvar p = 0; p < NPKT; p++) begin : g_pkt
    ts_cap_qual u_qual (
      .valid_i  (pkt_valid[p]),
      .type_ok_i(pkt_type_ok[p]),
      .fcs_ok_i (pkt_fcs_ok[p]),
      .whole_i  (pkt_whole_octets[p]),
      .commit_o (commit[p])
    );
    ts_cap_idreg u_id (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (wr[p]),
      .seq_i (pkt_seq_id[p*SEQ_W +: SEQ_W]),
      .uuid_i(pkt_src_uuid[p*UUID_W +: UUID_W]),
      .hi_o  (id_hi[p*WORD_W +: WORD_W]),
      .lo_o  (id_lo[p*WORD_W +: WORD_W])
    );
  end

  for (genvar g = 0; g < NGPIO; g++) begin : g_gpio
    assign commit[NPKT+g] = gpio_evt[g];
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    ts_cap_lockctl u_lock (
      .clk   (clk),
      .rst_n (rst_n),
      .fire_i(commit[b]),
      .clr_i (clr_eff[b]),
      .lock_i(lock_en[b]),
      .we_o  (wr[b]),
      .flag_o(flags[b])
    );
    ts_cap_clkreg u_clk (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (wr[b]),
      .time_i(time_in),
      .hi_o  (cap_hi[b*WORD_W +: WORD_W]),
      .lo_o  (cap_lo[b*WORD_W +: WORD_W])
    );

    // R7
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_en[b] && flags[b] && !clr_eff[b]) |=>
        ($stable(cap_lo[b*WORD_W +: WORD_W]) && $stable(cap_hi[b*WORD_W +: WORD_W])));
    // R1
    no_commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit[b] |=> $stable(cap_lo[b*WORD_W +: WORD_W]));
  end

  assign irq = |(flags & int_en);
endmodule

// File: tb/sim_ts_capture_unit.sv
module sim_ts_capture_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NPORTS = 2;
  localparam int NGPIO  = 2;
  localparam int NPKT   = 2 * NPORTS;
  localparam int NB     = NPKT + NGPIO;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] time_in = 64'h0000_0001_FFFF_FFF0;
  logic [NPKT-1:0] pkt_valid = '0, pkt_type_ok = '0, pkt_fcs_ok = '0, pkt_whole_octets = '0;
  logic [NPKT*16-1:0] pkt_seq_id = '0;
  logic [NPKT*48-1:0] pkt_src_uuid = '0;
  logic [NGPIO-1:0] gpio_evt = '0;
  logic [NB-1:0] lock_en = '0, int_en = '0, flag_clr = '0;
  logic flag_clr_we = 1'b0;
  logic [NB-1:0] flags;
  logic irq;
  logic [NB*32-1:0] cap_hi, cap_lo;
  logic [NPKT*32-1:0] id_hi, id_lo;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_hi [NB];
  logic [31:0] m_lo [NB];
  logic [31:0] m_ih [NPKT];
  logic [31:0] m_il [NPKT];
  logic [NB-1:0] m_flag;

  ts_capture_unit u0 (
    .clk(clk), .rst_n(rst_n), .time_in(time_in),
    .pkt_valid(pkt_valid), .pkt_type_ok(pkt_type_ok), .pkt_fcs_ok(pkt_fcs_ok),
    .pkt_whole_octets(pkt_whole_octets), .pkt_seq_id(pkt_seq_id),
    .pkt_src_uuid(pkt_src_uuid), .gpio_evt(gpio_evt), .lock_en(lock_en),
    .int_en(int_en), .flag_clr_we(flag_clr_we), .flag_clr(flag_clr),
    .flags(flags), .irq(irq), .cap_hi(cap_hi), .cap_lo(cap_lo),
    .id_hi(id_hi), .id_lo(id_lo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL R11 watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic commit_exp(int b);
    if (b < NPKT) return pkt_valid[b] & pkt_type_ok[b] & pkt_fcs_ok[b] & pkt_whole_octets[b];
    return gpio_evt[b-NPKT];
  endfunction

  function automatic logic irq_exp();
    return |(m_flag & int_en);
  endfunction

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin m_hi[b] = '0; m_lo[b] = '0; end
    for (int p = 0; p < NPKT; p++) begin m_ih[p] = '0; m_il[p] = '0; end
    m_flag = '0;
  endtask

  task automatic model_step();
    logic [NB-1:0] nf;
    nf = m_flag;
    for (int b = 0; b < NB; b++) begin
      logic fire, clr, held;
      fire = commit_exp(b);
      clr  = flag_clr_we & flag_clr[b];
      held = lock_en[b] & m_flag[b] & ~clr;
      if (fire && !held) begin
        m_hi[b] = time_in[63:32];
        m_lo[b] = time_in[31:0];
        if (b < NPKT) begin
          m_ih[b] = {pkt_seq_id[b*16 +: 16], pkt_src_uuid[b*48+32 +: 16]};
          m_il[b] = pkt_src_uuid[b*48 +: 32];
        end
      end
      if (fire) nf[b] = 1'b1;
      else if (clr) nf[b] = 1'b0;
    end
    m_flag = nf;
  endtask

  task automatic cmp32(string tag, string fld, int b, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s bank %0d actual=%h expected=%h", tag, fld, b, act, exp);
    end
  endtask

  task automatic compare(string tag);
    for (int b = 0; b < NB; b++) begin
      cmp32({tag, "/R2"}, "cap_hi", b, cap_hi[b*32 +: 32], m_hi[b]);
      cmp32({tag, "/R2"}, "cap_lo", b, cap_lo[b*32 +: 32], m_lo[b]);
    end
    for (int p = 0; p < NPKT; p++) begin
      cmp32({tag, "/R3"}, "id_hi", p, id_hi[p*32 +: 32], m_ih[p]);
      cmp32({tag, "/R3"}, "id_lo", p, id_lo[p*32 +: 32], m_il[p]);
    end
    cmp32({tag, "/R4"}, "flags", 0, 32'(flags), 32'(m_flag));
    cmp32({tag, "/R5"}, "irq", 0, 32'(irq), 32'(irq_exp()));
  endtask

  task automatic idle();
    pkt_valid = '0; pkt_type_ok = '0; pkt_fcs_ok = '0; pkt_whole_octets = '0;
    gpio_evt = '0; flag_clr_we = 1'b0; flag_clr = '0;
  endtask

  task automatic tick(string tag);
    model_step();
    @(posedge clk);
    #1;
    compare(tag);
    time_in = time_in + 64'd1 + 64'($urandom % 5);
    idle();
  endtask

  task automatic pkt(int p, logic v, logic t, logic f, logic w);
    pkt_valid[p] = v; pkt_type_ok[p] = t; pkt_fcs_ok[p] = f; pkt_whole_octets[p] = w;
    pkt_seq_id[p*16 +: 16] = 16'($urandom);
    pkt_src_uuid[p*48 +: 48] = {16'($urandom), $urandom};
  endtask

  task automatic clear(logic [NB-1:0] m);
    flag_clr_we = 1'b1; flag_clr = m;
  endtask

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    idle();
    repeat (2) @(posedge clk);
    #1;
    compare("R11");
    rst_n = 1'b1;

    // R1: each qualifier low blocks the commit
    pkt(0, 1, 1, 0, 1); tick("R1");
    pkt(0, 1, 0, 1, 1); tick("R1");
    pkt(0, 1, 1, 1, 0); tick("R1");
    pkt(0, 0, 1, 1, 1); tick("R1");
    // R2 / R3: full commit stores raw time and ids
    pkt(0, 1, 1, 1, 1); tick("R2");
    pkt(3, 1, 1, 1, 1); tick("R3");
    // R5: interrupt masking
    int_en = 6'b000001; tick("R5");
    int_en = 6'b000100; tick("R5");
    int_en = '1;
    // R6: zero bits and missing strobe have no effect
    flag_clr_we = 1'b0; flag_clr = '1; tick("R6");
    clear(6'b000000); tick("R6");
    clear(6'b000001); tick("R6");
    clear('1); tick("R6");
    // R7: locked bank holds first capture
    lock_en = 6'b000010;
    pkt(1, 1, 1, 1, 1); tick("R7");
    pkt(1, 1, 1, 1, 1); tick("R7");
    pkt(1, 1, 1, 1, 1); tick("R7");
    clear(6'b000010); tick("R7");
    pkt(1, 1, 1, 1, 1); tick("R7");
    // R9: capture and clear together on a locked bank
    pkt(1, 1, 1, 1, 1); clear(6'b000010); tick("R9");
    tick("R9");
    // R8: unlocked bank overwrites
    pkt(2, 1, 1, 1, 1); tick("R8");
    pkt(2, 1, 1, 1, 1); tick("R8");
    tick("R8");
    // R10: GPIO banks with lock
    lock_en = 6'b100000;
    gpio_evt = 2'b11; tick("R10");
    gpio_evt = 2'b11; tick("R10");
    clear(6'b100000); tick("R10");
    gpio_evt = 2'b10; tick("R10");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      if (i % 16 == 0) begin
        lock_en = NB'($urandom);
        int_en = NB'($urandom);
      end
      for (int p = 0; p < NPKT; p++)
        pkt(p, ($urandom % 3) == 0, ($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 10) != 0);
      gpio_evt = NGPIO'($urandom) & NGPIO'($urandom);
      if (($urandom % 4) == 0) clear(NB'($urandom));
      tick("RND");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule